// File: doc/BRIEF.md
# PWM Action Qualifier

This block turns time-base event strobes into two registered PWM output levels. Each clock it looks at six event strobes. Two come from the counter reaching zero and reaching its period value. The other four come from compare A and compare B matches, each split by whether the counter was counting up or down. Every output has its own 12-bit control word that assigns one 2-bit action to each event. The action can be nothing, drive low, drive high or invert.

A time-base counter and the compare logic sit upstream and produce the strobes. The block only decides which level each pin takes next. The same structure gives several waveform types:

- asymmetric pulses from an up-counting base (high at zero, low at a compare match);
- symmetric, centre-aligned pulses from an up-down base (high on the up-count match, low on the down-count match);
- edges placed independently by two compares;
- a half-rate square wave made by inverting on every zero event.

The active-low reset is asserted asynchronously and released synchronously inside the block. Both pins then start low.

Top module: `pwm_aq_top`

## Requirements
- R1: After reset both `pwm_a_o` and `pwm_b_o` are low.
- R2: An event whose 2-bit field holds code 10 drives that output high at the clock edge that samples the strobe.
- R3: An event whose field holds code 01 drives that output low at the clock edge that samples the strobe.
- R4: An event whose field holds code 11 inverts that output at the clock edge that samples the strobe.
- R5: In a cycle with no strobe, or where every active strobe has code 00, both outputs keep their level.
- R6: When several strobes with non-zero codes coincide, only the highest-ranked one acts. The ranking from highest to lowest is zero, period, compare A up, compare B up, compare A down, compare B down.
- R7: A strobe whose field holds code 00 takes no part in the ranking, so a lower-ranked strobe with an action still applies.
- R8: Output A uses only `ctl_a_i` and output B uses only `ctl_b_i`. One strobe can therefore set one pin and clear the other.
- R9: Changing a control word in a cycle with no strobe leaves the outputs unchanged. The new codes govern the next strobes that arrive.
- R10: Event bit positions in `evt_i`: 0 zero, 1 period, 2 compare A up, 3 compare A down, 4 compare B up, 5 compare B down. The field for event bit k sits at bits [2k+1:2k] of each control word.
- R11: Driven by an up-count base (set on zero, clear on compare A up), output A is high for exactly the compare value in counts each period. Driven by an up-down base (set on compare A up, clear on compare A down), the pulse is symmetric about the period point. A zero-event toggle on output B gives a square wave at half the period rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_i | input | 6 | Event strobes, one bit per event (see R10) |
| ctl_a_i | input | 12 | Action codes for output A, 2 bits per event |
| ctl_b_i | input | 12 | Action codes for output B, 2 bits per event |
| pwm_a_o | output | 1 | Registered PWM output A |
| pwm_b_o | output | 1 | Registered PWM output B |

## Verification
Some properties are checked by assertions on every cycle:

- a resolved set, clear or invert action shows on the pin one edge later;
- an idle cycle leaves both pins stable;
- a zero-event action always wins arbitration.

The full ranking among coincident compare strobes, the skipping of no-action strobes, and the independence of the two control words can only be shown by the bench's targeted scenarios. So can the whole-period waveforms (asymmetric pulse width, symmetric centring, half-rate toggle). The bench compares these against a reference model that resolves priority by a first-match search.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int unsigned AQ_EVT_N  = 6;
  localparam int unsigned AQ_CODE_W = 2;
  localparam int unsigned AQ_OUT_N  = 2;

  // event bit positions in the strobe vector
  localparam int unsigned EV_ZERO = 0;
  localparam int unsigned EV_PRD  = 1;
  localparam int unsigned EV_CAU  = 2;
  localparam int unsigned EV_CAD  = 3;
  localparam int unsigned EV_CBU  = 4;
  localparam int unsigned EV_CBD  = 5;

  typedef enum logic [AQ_CODE_W-1:0] {
    AQ_NONE = 2'b00,
    AQ_CLR  = 2'b01,
    AQ_SET  = 2'b10,
    AQ_TGL  = 2'b11
  } aq_act_e;

  // rank 0 is the highest priority; maps a rank to an event bit index
  function automatic int unsigned rank_to_evt(input int unsigned rank);
    case (rank)
      0:       return EV_ZERO;
      1:       return EV_PRD;
      2:       return EV_CAU;
      3:       return EV_CBU;
      4:       return EV_CAD;
      default: return EV_CBD;
    endcase
  endfunction

endpackage

// File: rtl/aq_rst_sync.sv
module aq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/aq_arbiter.sv
module aq_arbiter
  import pwm_aq_pkg::*;
#(
  parameter int unsigned EVT_N  = AQ_EVT_N,
  parameter int unsigned CODE_W = AQ_CODE_W,
  localparam int unsigned CTL_W = EVT_N * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt,
  input  logic [CTL_W-1:0] ctl,
  output aq_act_e          act
);
  // walk from lowest rank to highest so the highest-ranked acting event
  // is the last to write the result
  always_comb begin
    act = AQ_NONE;
    for (int r = int'(EVT_N) - 1; r >= 0; r--) begin
      if (evt[rank_to_evt(r)] &&
          ctl[CODE_W*rank_to_evt(r) +: CODE_W] != AQ_NONE) begin
        act = aq_act_e'(ctl[CODE_W*rank_to_evt(r) +: CODE_W]);
      end
    end
  end

  assert_zero_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[EV_ZERO] && ctl[CODE_W*EV_ZERO +: CODE_W] != AQ_NONE)
      |-> (act == aq_act_e'(ctl[CODE_W*EV_ZERO +: CODE_W])));
endmodule

// File: rtl/aq_pin_reg.sv
module aq_pin_reg
  import pwm_aq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  aq_act_e act,
  output logic    pin
);
  logic pin_q, pin_nxt, pin_en;

  always_comb begin
    pin_en  = (act != AQ_NONE);
    pin_nxt = pin_q;
    case (act)
      AQ_CLR:  pin_nxt = 1'b0;
      AQ_SET:  pin_nxt = 1'b1;
      AQ_TGL:  pin_nxt = ~pin_q;
      default: pin_nxt = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_en) pin_q <= pin_nxt;
  end

  assign pin = pin_q;

  assert_set_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == AQ_SET) |=> pin_q);
  assert_clear_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act == AQ_CLR) |=> !pin_q);
  assert_toggle_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == AQ_TGL) |=> (pin_q != $past(pin_q)));
endmodule

// File: rtl/aq_channel.sv
module aq_channel
  import pwm_aq_pkg::*;
#(
  parameter int unsigned EVT_N  = AQ_EVT_N,
  parameter int unsigned CODE_W = AQ_CODE_W,
  localparam int unsigned CTL_W = EVT_N * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt,
  input  logic [CTL_W-1:0] ctl,
  output logic             pin
);
  aq_act_e act;

  aq_arbiter #(.EVT_N(EVT_N), .CODE_W(CODE_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ctl(ctl), .act(act)
  );

  aq_pin_reg u_reg (
    .clk(clk), .rst_n(rst_n), .act(act), .pin(pin)
  );
endmodule

// File: rtl/pwm_aq_top.sv
module pwm_aq_top
  import pwm_aq_pkg::*;
#(
  parameter int unsigned EVT_N     = AQ_EVT_N,
  parameter int unsigned CODE_W    = AQ_CODE_W,
  parameter int unsigned SYNC_STGS = 2,
  localparam int unsigned CTL_W    = EVT_N * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [CTL_W-1:0] ctl_a_i,
  input  logic [CTL_W-1:0] ctl_b_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o
);
  localparam int unsigned OUT_N = AQ_OUT_N;

  logic                       rst_q_n;
  logic [OUT_N-1:0][CTL_W-1:0] ctl_arr;
  logic [OUT_N-1:0]            pin_arr;

  aq_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  assign ctl_arr[0] = ctl_a_i;
  assign ctl_arr[1] = ctl_b_i;

  for (genvar g = 0; g < OUT_N; g++) begin : g_ch
    aq_channel #(.EVT_N(EVT_N), .CODE_W(CODE_W)) u_ch (
      .clk(clk), .rst_n(rst_q_n), .evt(evt_i), .ctl(ctl_arr[g]),
      .pin(pin_arr[g])
    );
  end

  assign pwm_a_o = pin_arr[0];
  assign pwm_b_o = pin_arr[1];

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (evt_i == '0) |=> $stable({pwm_a_o, pwm_b_o}));
endmodule

// File: tb/pwm_aq_top_tb.sv
module pwm_aq_top_tb;
  typedef struct {
    logic  a;
    logic  b;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  evt;
  logic [11:0] ctl_a, ctl_b;
  logic        pwm_a, pwm_b;
  logic        mdl_a, mdl_b;
  int          n_chk = 0, n_bad = 0;
  exp_t        sb[$];

  always #10 clk = ~clk;

  pwm_aq_top u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ctl_a_i(ctl_a), .ctl_b_i(ctl_b),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
  );

  // codes: 00 none, 01 low, 10 high, 11 invert
  function automatic logic [11:0] fld(input int ev, input logic [1:0] code);
    return 12'(code) << (2 * ev);
  endfunction

  function automatic logic model(input logic cur, input logic [5:0] ev,
                                 input logic [11:0] ctl);
    int ord[6] = '{0, 1, 2, 4, 3, 5};
    foreach (ord[i]) begin
      logic [1:0] c;
      c = ctl[2*ord[i] +: 2];
      if (ev[ord[i]] && c != 2'b00) begin
        if (c == 2'b01) return 1'b0;
        if (c == 2'b10) return 1'b1;
        return ~cur;
      end
    end
    return cur;
  endfunction

  task automatic drive(input logic [5:0] ev, input logic [11:0] ca,
                       input logic [11:0] cb, input string tag);
    exp_t e;
    @(negedge clk);
    evt = ev; ctl_a = ca; ctl_b = cb;
    mdl_a = model(mdl_a, ev, ca);
    mdl_b = model(mdl_b, ev, cb);
    e.a = mdl_a; e.b = mdl_b; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: samples mid-high phase after the edge that consumed the input
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (pwm_a !== e.a || pwm_b !== e.b) begin
          n_bad++;
          $display("FAIL %s: got a=%b b=%b, expected a=%b b=%b",
                   e.tag, pwm_a, pwm_b, e.a, e.b);
        end
      end
    end
  end

  // time-base generator: up (mode 0) or up-down (mode 1), period P
  task automatic run_base(input int mode, input int p, input int cmpa,
                          input int cmpb, input logic [11:0] ca,
                          input logic [11:0] cb, input int periods,
                          input string tag);
    for (int k = 0; k < periods; k++) begin
      if (mode == 0) begin
        for (int c = 0; c <= p; c++) begin
          logic [5:0] ev;
          ev = '0;
          ev[0] = (c == 0); ev[1] = (c == p);
          ev[2] = (c == cmpa); ev[4] = (c == cmpb);
          drive(ev, ca, cb, tag);
        end
      end else begin
        for (int s = 0; s < 2 * p; s++) begin
          logic [5:0] ev;
          int c;
          logic up;
          up = (s < p);
          c  = up ? s : 2 * p - s;
          ev = '0;
          ev[0] = (c == 0); ev[1] = (c == p);
          ev[2] = up && (c == cmpa); ev[3] = !up && (c == cmpa);
          ev[4] = up && (c == cmpb); ev[5] = !up && (c == cmpb);
          drive(ev, ca, cb, tag);
        end
      end
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi_cnt;
    rst_n = 1'b0; evt = '0; ctl_a = '0; ctl_b = '0;
    mdl_a = 1'b0; mdl_b = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (pwm_a !== 1'b0 || pwm_b !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got a=%b b=%b, expected a=0 b=0", pwm_a, pwm_b);
    end

    // R2 / R10: zero event at bit 0, set code
    drive(6'b000001, fld(0, 2'b10), fld(0, 2'b10), "R2 set on zero");
    // R3: period event at bit 1, clear code
    drive(6'b000010, fld(1, 2'b01), fld(1, 2'b01), "R3 clear on period");
    // R4: invert twice on compare B down (bit 5)
    drive(6'b100000, fld(5, 2'b11), fld(5, 2'b11), "R4 toggle first");
    drive(6'b100000, fld(5, 2'b11), fld(5, 2'b11), "R4 toggle second");
    // R5: no event, then event with code none
    drive(6'b000000, 12'hFFF, 12'hFFF, "R5 idle hold");
    drive(6'b111111, 12'h000, 12'h000, "R5 none codes");
    // R9: control change without event, then event uses the new code
    drive(6'b000000, fld(2, 2'b10), fld(2, 2'b10), "R9 ctl change only");
    drive(6'b000100, fld(2, 2'b10), fld(2, 2'b10), "R9 next event new code");
    // R6: zero clear beats compare A up set
    drive(6'b000101, fld(0, 2'b01) | fld(2, 2'b10),
          fld(0, 2'b01) | fld(2, 2'b10), "R6 zero over cau");
    // R6: compare up beats compare down
    drive(6'b001100, fld(2, 2'b10) | fld(3, 2'b01),
          fld(4, 2'b10) | fld(5, 2'b01), "R6 up over down");
    drive(6'b110000, fld(4, 2'b01) | fld(5, 2'b10),
          fld(4, 2'b01) | fld(5, 2'b10), "R6 cbu over cbd");
    // R6: period beats compare A up; compare A up beats compare B up
    drive(6'b010110, fld(1, 2'b10) | fld(2, 2'b01),
          fld(2, 2'b01) | fld(4, 2'b10), "R6 prd over cau, cau over cbu");
    // R7: none on zero lets compare A down act
    drive(6'b001001, fld(3, 2'b11), fld(3, 2'b11), "R7 skip none");
    // R8: one event, opposite actions per pin
    drive(6'b000001, fld(0, 2'b10), fld(0, 2'b01), "R8 independent");
    drive(6'b000001, fld(0, 2'b01), fld(0, 2'b10), "R8 swapped");

    // R11: up-count asymmetric A, zero toggle on B
    run_base(0, 9, 4, 7, fld(0, 2'b10) | fld(2, 2'b01), fld(0, 2'b11), 3,
             "R11 up-count asym");
    // R11: up-down symmetric A, B clear on CBU set on CBD
    run_base(1, 8, 5, 3, fld(2, 2'b10) | fld(3, 2'b01),
             fld(4, 2'b01) | fld(5, 2'b10), 3, "R11 up-down sym");
    // R11: independent edges A (set CAU, clear CBU); B clear zero set period
    run_base(0, 9, 2, 6, fld(2, 2'b10) | fld(4, 2'b01),
             fld(0, 2'b01) | fld(1, 2'b10), 2, "R11 independent edges");

    // R11: explicit width count for up-count pulse, compare = 3
    while (sb.size() > 0) @(posedge clk);
    hi_cnt = 0;
    for (int c = 0; c <= 9; c++) begin
      @(negedge clk);
      evt = '0; evt[0] = (c == 0); evt[2] = (c == 3);
      ctl_a = fld(0, 2'b10) | fld(2, 2'b01);
      ctl_b = '0;
      @(posedge clk); #5;
      if (pwm_a) hi_cnt++;
    end
    n_chk++;
    if (hi_cnt != 3) begin
      n_bad++;
      $display("FAIL R11 pulse width: got %0d, expected 3", hi_cnt);
    end

    @(negedge clk) evt = '0;
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule